// File: doc/BRIEF.md
# Glitch-Free Delay-Line Control Encoder

This block drives the control pins of a NAND-based digitally controlled delay line. The line is built from `N_ELEM` delay elements, and each element takes a pair of control bits (S, T). The block turns a binary delay code into those pairs. Each element ends up in one of three legal states:

| State | S | T | Meaning |
|-------|---|---|---------|
| pass | 0 | 1 | the return chain runs through the element |
| turn | 1 | 1 | the forward signal is folded back onto the return path |
| post-turn | 1 | 0 | the element lets the turn element before it drive the return path |

For code c, element c is in turn and element c+1 is in post-turn. Every other element is in pass.

A code change is never applied in one step. The block stages it across successive clock edges, and it uses both clock edges. The T vector changes first. S bits that must rise follow one edge later. S bits that must fall follow one edge after that. This keeps the S control behind T, so the line does not glitch when the code moves.

A sequencer in the enumerated states `SEQ_IDLE`, `SEQ_RISE` and `SEQ_FALL` runs this staging. It has three transitions:

- **accept** (`SEQ_IDLE` to `SEQ_RISE`): taken at any edge that sees the load strobe. It writes T.
- **raise** (`SEQ_RISE` to `SEQ_FALL`): taken at the next edge. It ORs in the new S bits.
- **settle** (`SEQ_FALL` to `SEQ_IDLE`): taken at the edge after that. It writes the final S.

Without a strobe, `SEQ_IDLE` stays where it is. All state is held in dual-edge registers. Each register is built from one rising-edge flop and one falling-edge flop, combined by XOR.

Top module: `nand_dcdl_ctrl`

## Requirements
- R1: While reset is held and after its release, the outputs hold code 0. That means `ctl_s` = bits 0 and 1 set, `ctl_t` = all ones except bit 1, and `busy` = 0.
- R2: When idle after a load of legal code c (0 to N_ELEM-2), `ctl_s` has exactly bits c and c+1 set. `ctl_t` has exactly bit c+1 cleared. Bit i of each vector controls element i.
- R3: `ctl_t[0]` is 1 at all times.
- R4: At the first clock edge (rising or falling) that samples `dly_load` high while idle, `ctl_t` takes the new code's value and `ctl_s` does not change.
- R5: S bits that go from 0 to 1 change at the edge after the one that updated T.
- R6: S bits that go from 1 to 0 change two edges after the one that updated T.
- R7: `busy` goes high at the edge that accepts a load. It goes low at the edge that applies the falling S bits, so a new load can be accepted at the following edge.
- R8: A strobe sampled while `busy` is high has no effect on `ctl_s`, `ctl_t` or the code that is finally reached.
- R9: A code above N_ELEM-2 is treated as N_ELEM-2.
- R10: While `busy` is low, no element has S=0 with T=0.
- R11: Loads accepted on a rising edge and loads accepted on a falling edge follow the same staged timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges are active |
| rst | input | 1 | Asynchronous reset, active high |
| dly_code | input | CW | Requested delay code |
| dly_load | input | 1 | Load strobe, sampled on every clock edge |
| ctl_s | output | N_ELEM | S control bit per element |
| ctl_t | output | N_ELEM | T control bit per element |
| busy | output | 1 | High while a code change is being staged |

## Verification
Every ordered pair of legal codes is loaded back to back, and the outputs are compared after each of the three staging edges. The pairs cover moves up by one, down by one, long jumps and reloads of the same code. Moves of one step overlap the old turn/post-turn pair, while jumps do not. This tells a design that stages S bits by rise and fall apart from one that writes S in a single step. Because each load takes an odd number of edges, consecutive loads alternate between rising-edge and falling-edge acceptance. Strobes held across a busy window, and codes above the legal range, exercise the ignore and saturation rules.

// File: rtl/dlenc_pkg.sv
package dlenc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RISE = 2'd1,
        SEQ_FALL = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dlenc_dereg.sv
// Register that captures d on every clock edge: a rising-edge half and a
// falling-edge half whose XOR forms the visible value.
module dlenc_dereg #(
    parameter int              W    = 1,
    parameter logic [W-1:0]    INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] rise_half;
    logic [W-1:0] fall_half;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rise_half <= '0;
        end else begin
            rise_half <= d ^ fall_half ^ INIT;
        end
    end

    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            fall_half <= '0;
        end else begin
            fall_half <= d ^ rise_half ^ INIT;
        end
    end

    assign q = rise_half ^ fall_half ^ INIT;

endmodule

// File: rtl/dlenc_decode.sv
// Maps a delay code onto target S and T vectors: turn at the code, post-turn
// just after it, pass everywhere else.
module dlenc_decode #(
    parameter int N_ELEM = 8,
    parameter int CW     = $clog2(N_ELEM)
) (
    input  logic [CW-1:0]     code_i,
    output logic [N_ELEM-1:0] s_o,
    output logic [N_ELEM-1:0] t_o
);

    for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
        if (i == 0) begin : g_head
            assign s_o[i] = (code_i == CW'(0));
            assign t_o[i] = 1'b1;
        end else begin : g_body
            logic is_turn;
            logic is_post;
            assign is_turn = (code_i == CW'(i));
            assign is_post = (code_i == CW'(i - 1));
            assign s_o[i]  = is_turn | is_post;
            assign t_o[i]  = ~is_post;
        end
    end

endmodule

// File: rtl/dlenc_seq.sv
// Staging sequencer: accept -> raise -> settle, stepped on both clock edges.
module dlenc_seq
    import dlenc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic busy_o,
    output logic t_we_o,
    output logic s_rise_o,
    output logic s_fall_o,
    output logic use_stored_o
);

    seq_state_e state;
    seq_state_e state_nx;
    logic [1:0] state_raw;

    // state register (dual-edge)
    dlenc_dereg #(.W(2), .INIT(2'(SEQ_IDLE))) u_state_reg (
        .clk (clk),
        .rst (rst),
        .d   (2'(state_nx)),
        .q   (state_raw)
    );

    assign state = seq_state_e'(state_raw);

    always_comb begin
        unique case (state)
            SEQ_IDLE: state_nx = load_i ? SEQ_RISE : SEQ_IDLE;
            SEQ_RISE: state_nx = SEQ_FALL;
            SEQ_FALL: state_nx = SEQ_IDLE;
            default:  state_nx = SEQ_IDLE;
        endcase
    end

    always_comb begin
        busy_o       = 1'b0;
        t_we_o       = 1'b0;
        s_rise_o     = 1'b0;
        s_fall_o     = 1'b0;
        use_stored_o = 1'b1;
        unique case (state)
            SEQ_IDLE: begin
                t_we_o       = load_i;
                use_stored_o = 1'b0;
            end
            SEQ_RISE: begin
                busy_o   = 1'b1;
                s_rise_o = 1'b1;
            end
            SEQ_FALL: begin
                busy_o   = 1'b1;
                s_fall_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nand_dcdl_ctrl.sv
module nand_dcdl_ctrl #(
    parameter int N_ELEM = 8,
    parameter int CW     = $clog2(N_ELEM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     dly_code,
    input  logic              dly_load,
    output logic [N_ELEM-1:0] ctl_s,
    output logic [N_ELEM-1:0] ctl_t,
    output logic              busy
);

    localparam int                CODE_MAX = N_ELEM - 2;
    localparam logic [N_ELEM-1:0] S_RESET  = N_ELEM'(3);
    localparam logic [N_ELEM-1:0] T_RESET  = ~N_ELEM'(2);

    logic              t_we;
    logic              s_rise;
    logic              s_fall;
    logic              use_stored;
    logic [CW-1:0]     code_sat;
    logic [CW-1:0]     code_q;
    logic [CW-1:0]     code_d;
    logic [CW-1:0]     dec_code;
    logic [N_ELEM-1:0] dec_s;
    logic [N_ELEM-1:0] dec_t;
    logic [N_ELEM-1:0] s_d;
    logic [N_ELEM-1:0] t_d;

    assign code_sat = (dly_code > CW'(CODE_MAX)) ? CW'(CODE_MAX) : dly_code;

    dlenc_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .load_i       (dly_load),
        .busy_o       (busy),
        .t_we_o       (t_we),
        .s_rise_o     (s_rise),
        .s_fall_o     (s_fall),
        .use_stored_o (use_stored)
    );

    // one decoder: incoming code while idle, stored target while staging
    assign dec_code = use_stored ? code_q : code_sat;

    dlenc_decode #(.N_ELEM(N_ELEM), .CW(CW)) u_decode (
        .code_i (dec_code),
        .s_o    (dec_s),
        .t_o    (dec_t)
    );

    assign code_d = t_we ? code_sat : code_q;
    assign t_d    = t_we ? dec_t : ctl_t;

    always_comb begin
        s_d = ctl_s;
        if (s_rise) begin
            s_d = ctl_s | dec_s;
        end else if (s_fall) begin
            s_d = dec_s;
        end
    end

    dlenc_dereg #(.W(CW), .INIT('0)) u_code_reg (
        .clk (clk), .rst (rst), .d (code_d), .q (code_q)
    );

    dlenc_dereg #(.W(N_ELEM), .INIT(T_RESET)) u_t_reg (
        .clk (clk), .rst (rst), .d (t_d), .q (ctl_t)
    );

    dlenc_dereg #(.W(N_ELEM), .INIT(S_RESET)) u_s_reg (
        .clk (clk), .rst (rst), .d (s_d), .q (ctl_s)
    );

endmodule

// File: rtl/nand_dcdl_ctrl_chk.sv
// Shadow registers hold each output as it was one clock edge earlier.
module nand_dcdl_ctrl_chk #(
    parameter int N_ELEM = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [N_ELEM-1:0] ctl_s,
    input logic [N_ELEM-1:0] ctl_t,
    input logic              busy
);

    logic [N_ELEM-1:0] prev_s;
    logic [N_ELEM-1:0] prev_t;
    logic              prev_busy;

    dlenc_dereg #(.W(N_ELEM), .INIT(N_ELEM'(3))) u_sh_s (
        .clk (clk), .rst (rst), .d (ctl_s), .q (prev_s)
    );
    dlenc_dereg #(.W(N_ELEM), .INIT(~N_ELEM'(2))) u_sh_t (
        .clk (clk), .rst (rst), .d (ctl_t), .q (prev_t)
    );
    dlenc_dereg #(.W(1), .INIT(1'b0)) u_sh_b (
        .clk (clk), .rst (rst), .d (busy), .q (prev_busy)
    );

    assert_t0_high_R3: assert property (@(posedge clk) disable iff (rst)
        ctl_t[0]);

    assert_idle_legal_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ((~ctl_s & ~ctl_t) == '0 && $countones(~ctl_t) == 1));

    assert_t_first_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_t != prev_t) |-> (!prev_busy && ctl_s == prev_s));

    assert_t_first_neg_R4: assert property (@(negedge clk) disable iff (rst)
        (ctl_t != prev_t) |-> (!prev_busy && ctl_s == prev_s));

    assert_s_rise_lag_R5: assert property (@(posedge clk) disable iff (rst)
        (|(ctl_s & ~prev_s)) |-> (prev_busy && busy));

    assert_s_rise_lag_neg_R5: assert property (@(negedge clk) disable iff (rst)
        (|(ctl_s & ~prev_s)) |-> (prev_busy && busy));

    assert_s_fall_lag_R6: assert property (@(posedge clk) disable iff (rst)
        (|(prev_s & ~ctl_s)) |-> (prev_busy && !busy));

    assert_s_fall_lag_neg_R6: assert property (@(negedge clk) disable iff (rst)
        (|(prev_s & ~ctl_s)) |-> (prev_busy && !busy));

endmodule

bind nand_dcdl_ctrl nand_dcdl_ctrl_chk #(.N_ELEM(N_ELEM)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ctl_s (ctl_s),
    .ctl_t (ctl_t),
    .busy  (busy)
);

// File: tb/nand_dcdl_ctrl_tb.sv
module nand_dcdl_ctrl_tb;

    localparam int N  = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] dly_code = '0;
    logic          dly_load = 1'b0;
    logic [N-1:0]  ctl_s;
    logic [N-1:0]  ctl_t;
    logic          busy;

    int total = 0;
    int bad   = 0;
    int cur   = 0;

    always #4 clk = ~clk;

    nand_dcdl_ctrl #(.N_ELEM(N), .CW(CW)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .dly_code (dly_code),
        .dly_load (dly_load),
        .ctl_s    (ctl_s),
        .ctl_t    (ctl_t),
        .busy     (busy)
    );

    function automatic logic [N-1:0] exp_s(input int c);
        return N'(3) << c;
    endfunction

    function automatic logic [N-1:0] exp_t(input int c);
        return ~(N'(1) << (c + 1));
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Called at a quarter point between edges; returns at the same phase.
    task automatic do_load(input int c, input int tgt);
        logic [N-1:0] old_s;
        old_s    = exp_s(cur);
        dly_code = CW'(c);
        dly_load = 1'b1;
        #4;                          // edge E0
        dly_load = 1'b0;
        chk("R4 R11 T after first edge", ctl_t, exp_t(tgt));
        chk("R4 S held at first edge", ctl_s, old_s);
        chk("R7 busy high after E0", N'(busy), N'(1));
        chk("R3 T0", N'(ctl_t[0]), N'(1));
        #4;                          // edge E1
        chk("R5 rising S one edge later", ctl_s, old_s | exp_s(tgt));
        chk("R7 busy high after E1", N'(busy), N'(1));
        #4;                          // edge E2
        chk("R6 falling S two edges later", ctl_s, exp_s(tgt));
        chk("R2 idle T encoding", ctl_t, exp_t(tgt));
        chk("R7 busy low after E2", N'(busy), N'(0));
        chk("R10 no S=0 T=0", ~ctl_s & ~ctl_t, '0);
        cur = tgt;
    endtask

    initial begin
        #6;
        chk("R1 reset S", ctl_s, exp_s(0));
        chk("R1 reset T", ctl_t, exp_t(0));
        chk("R1 reset busy", N'(busy), N'(0));
        #4 rst = 1'b0;               // t=10, between edges
        #8;
        chk("R1 S after release", ctl_s, exp_s(0));
        chk("R1 busy after release", N'(busy), N'(0));

        // all ordered pairs of legal codes, back to back
        for (int a = 0; a <= N - 2; a++) begin
            for (int b = 0; b <= N - 2; b++) begin
                do_load(a, a);
                do_load(b, b);
            end
        end

        // R9: codes above the legal range saturate
        do_load(0, 0);
        do_load(7, N - 2);
        do_load(2, 2);
        do_load(7, N - 2);

        // R8: strobe held through the busy window is ignored
        do_load(1, 1);
        dly_code = CW'(4);
        dly_load = 1'b1;
        #4;                          // E0 accepts 4
        dly_code = CW'(0);           // strobe stays high with another code
        chk("R8 T after accept", ctl_t, exp_t(4));
        #4;                          // E1: strobe ignored
        chk("R8 T unchanged during busy", ctl_t, exp_t(4));
        #4;                          // E2: strobe ignored
        dly_load = 1'b0;
        chk("R8 final S", ctl_s, exp_s(4));
        chk("R8 final T", ctl_t, exp_t(4));
        chk("R8 busy low", N'(busy), N'(0));
        #8;
        chk("R8 S stays after ignored load", ctl_s, exp_s(4));
        chk("R8 T stays after ignored load", ctl_t, exp_t(4));
        cur = 4;
        do_load(5, 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule